// File: doc/BRIEF.md
# PLL Rate Table Lookup Engine

This block keeps a small table of PLL operating points. Each entry holds an output rate and the settings that produce it: a reference divider, an output divider, a feedback multiplier and a loop bandwidth trim. Software or a boot sequencer fills the table through a write port. The table is kept sorted from the highest rate to the lowest. The first entry whose rate is zero marks the end of the table.

Two kinds of query are answered.

- A round query returns the best supported rate that does not exceed the request. It takes the first entry at or below the requested rate. If no entry qualifies, it falls back to the smallest valid entry.
- An exact query returns the settings of an entry whose rate equals the request. If no entry matches, it raises an error.

Queries enter on a valid/ready handshake. The engine walks the table one entry per clock and answers with a one-cycle done pulse. The result port has no back-pressure: the receiver must take the result in the pulse cycle. The result registers then hold their value until the next pulse. The request side sees back-pressure through `q_ready`, which is low for the whole scan.

Top module: `pll_rate_lookup`

## Requirements
- R1: After reset, `busy` and `r_done` are 0 and `q_ready` is 1. Every table entry reads as rate zero, so the table is empty.
- R2: When `wr_en` is high and the write is not dropped (see R10), the entry at `wr_idx` takes `wr_rate`, `wr_nr`, `wr_no`, `wr_nf` and `wr_bw` at the clock edge. A later query returns exactly those values.
- R3: The valid part of the table ends just before the first entry whose rate is zero. If no such entry exists, it ends at entry DEPTH-1. Entries after the end never take part in a result.
- R4: A round query (`q_exact`=0) returns the first entry, counting from index 0, whose rate is less than or equal to `q_rate`. It returns that entry's rate and settings with `r_err`=0.
- R5: When no valid entry is at or below the request, a round query returns the last valid entry (the smallest rate) with `r_err`=0.
- R6: An exact query (`q_exact`=1) returns the entry whose rate equals `q_rate`, with `r_err`=0. The scan stops with `r_err`=1 at the end of the table, or at the first entry whose rate is below the request.
- R7: With an empty table (entry 0 has rate zero), both query kinds end with `r_err`=1 after scanning one entry.
- R8: A query is accepted on a clock edge where `q_valid` and `q_ready` are both 1. `r_done` rises exactly N edges later, where N is the number of entries examined, and it is high for exactly one cycle.
- R9: From the edge after acceptance until the result edge, `busy` is 1 and `q_ready` is 0. No new query is taken in that time.
- R10: A write is dropped, leaving the table unchanged, in two cases: when it arrives while `busy` is 1, and when it arrives in the same cycle as an accepted query.
- R11: When `r_err` is 1, the result rate and all four settings are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_rate | input | 32 | Rate of the entry; 0 marks the end of the table |
| wr_nr | input | 6 | Reference divider setting |
| wr_no | input | 4 | Output divider setting |
| wr_nf | input | 13 | Feedback multiplier setting |
| wr_bw | input | 12 | Bandwidth trim setting |
| q_valid | input | 1 | Query request valid |
| q_ready | output | 1 | Engine can accept a query |
| q_exact | input | 1 | 1 = exact query, 0 = round query |
| q_rate | input | 32 | Requested rate |
| busy | output | 1 | Scan in progress |
| r_done | output | 1 | One-cycle result pulse |
| r_err | output | 1 | No entry satisfied the query |
| r_rate | output | 32 | Rate of the selected entry |
| r_nr | output | 6 | Reference divider of the selected entry |
| r_no | output | 4 | Output divider of the selected entry |
| r_nf | output | 13 | Feedback multiplier of the selected entry |
| r_bw | output | 12 | Bandwidth trim of the selected entry |

## Verification
A table write and a query acceptance can land on the same clock edge. The query always wins. The bench raises `wr_en` and `q_valid` together with a new rate for entry 0. It then checks, with follow-up exact queries, that the old rate is still found and the new one is missing.

A write can also arrive in the middle of a scan, and the same follow-up queries show that it had no effect. In both cases the bench also checks the result latency, which shows that the scan itself was not disturbed.

// File: rtl/pll_tbl_pkg.sv
package pll_tbl_pkg;
  localparam int RATE_W = 32;
  localparam int NR_W   = 6;
  localparam int NO_W   = 4;
  localparam int NF_W   = 13;
  localparam int BW_W   = 12;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic [NR_W-1:0]   nr;
    logic [NO_W-1:0]   no;
    logic [NF_W-1:0]   nf;
    logic [BW_W-1:0]   bw;
  } tbl_ent_t;

  typedef enum logic {
    Q_ROUND = 1'b0,
    Q_EXACT = 1'b1
  } qmode_t;
endpackage

// File: rtl/pll_tbl_store.sv
module pll_tbl_store
  import pll_tbl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  tbl_ent_t         wdata,
  input  logic [IDX_W-1:0] ridx,
  output tbl_ent_t         rdata
);
  tbl_ent_t cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < DEPTH; i++)
        if (widx == IDX_W'(i)) cells[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++)
      if (ridx == IDX_W'(i)) rdata = cells[i];
  end
endmodule

// File: rtl/pll_tbl_cmp.sv
module pll_tbl_cmp
  import pll_tbl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  tbl_ent_t          ent,
  input  logic [RATE_W-1:0] req,
  input  qmode_t            mode,
  input  logic [IDX_W-1:0]  idx,
  output logic              stop,
  output logic              err,
  output logic              use_prev
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic sentinel, at_last, at_first, le_req, eq_req, lt_req;

  assign sentinel = (ent.rate == '0);
  assign at_last  = (idx == LAST);
  assign at_first = (idx == '0);
  assign le_req   = (ent.rate <= req);
  assign eq_req   = (ent.rate == req);
  assign lt_req   = (ent.rate < req);

  always_comb begin
    stop     = 1'b0;
    err      = 1'b0;
    use_prev = 1'b0;
    if (sentinel) begin
      stop     = 1'b1;
      err      = (mode == Q_EXACT) || at_first;
      use_prev = (mode == Q_ROUND) && !at_first;
    end else if (mode == Q_ROUND) begin
      stop = le_req || at_last;
    end else begin
      if (eq_req) begin
        stop = 1'b1;
      end else if (lt_req || at_last) begin
        stop = 1'b1;
        err  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_tbl_scan.sv
module pll_tbl_scan
  import pll_tbl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_valid,
  input  logic              q_exact,
  input  logic [RATE_W-1:0] q_rate,
  output logic              q_ready,
  output logic              accept,
  output logic              busy,
  output logic [IDX_W-1:0]  ridx,
  input  tbl_ent_t          rent,
  output logic [RATE_W-1:0] req,
  output qmode_t            mode,
  input  logic              stop,
  input  logic              err,
  input  logic              use_prev,
  output tbl_ent_t          res,
  output logic              res_err,
  output logic              done
);
  typedef enum logic {S_IDLE, S_SCAN} st_t;
  st_t      st;
  tbl_ent_t prev;

  assign q_ready = (st == S_IDLE);
  assign busy    = (st == S_SCAN);
  assign accept  = q_valid && q_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ridx    <= '0;
      req     <= '0;
      mode    <= Q_ROUND;
      prev    <= '0;
      res     <= '0;
      res_err <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (accept) begin
            req  <= q_rate;
            mode <= q_exact ? Q_EXACT : Q_ROUND;
            ridx <= '0;
            st   <= S_SCAN;
          end
        end
        default: begin
          prev <= rent;
          if (stop) begin
            st      <= S_IDLE;
            done    <= 1'b1;
            res_err <= err;
            res     <= err ? '0 : (use_prev ? prev : rent);
          end else begin
            ridx <= ridx + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pll_rate_lookup.sv
module pll_rate_lookup
  import pll_tbl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [RATE_W-1:0] wr_rate,
  input  logic [NR_W-1:0]   wr_nr,
  input  logic [NO_W-1:0]   wr_no,
  input  logic [NF_W-1:0]   wr_nf,
  input  logic [BW_W-1:0]   wr_bw,
  input  logic              q_valid,
  output logic              q_ready,
  input  logic              q_exact,
  input  logic [RATE_W-1:0] q_rate,
  output logic              busy,
  output logic              r_done,
  output logic              r_err,
  output logic [RATE_W-1:0] r_rate,
  output logic [NR_W-1:0]   r_nr,
  output logic [NO_W-1:0]   r_no,
  output logic [NF_W-1:0]   r_nf,
  output logic [BW_W-1:0]   r_bw
);
  logic              accept, wr_ok, stop, err, use_prev;
  logic [IDX_W-1:0]  ridx;
  logic [RATE_W-1:0] req;
  qmode_t            mode;
  tbl_ent_t          wdata, rent, res;

  assign wdata = '{rate: wr_rate, nr: wr_nr, no: wr_no, nf: wr_nf, bw: wr_bw};
  assign wr_ok = wr_en && !busy && !accept;

  pll_tbl_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_ok), .widx(wr_idx), .wdata(wdata),
    .ridx(ridx), .rdata(rent)
  );

  pll_tbl_cmp #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_cmp (
    .ent(rent), .req(req), .mode(mode), .idx(ridx),
    .stop(stop), .err(err), .use_prev(use_prev)
  );

  pll_tbl_scan #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_exact(q_exact),
    .q_rate(q_rate), .q_ready(q_ready), .accept(accept), .busy(busy),
    .ridx(ridx), .rent(rent), .req(req), .mode(mode), .stop(stop),
    .err(err), .use_prev(use_prev), .res(res), .res_err(r_err), .done(r_done)
  );

  assign r_rate = res.rate;
  assign r_nr   = res.nr;
  assign r_no   = res.no;
  assign r_nf   = res.nf;
  assign r_bw   = res.bw;
endmodule

// File: rtl/pll_rate_lookup_chk.sv
module pll_rate_lookup_chk
  import pll_tbl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              q_valid,
  input logic              q_ready,
  input logic              q_exact,
  input logic [RATE_W-1:0] q_rate,
  input logic              busy,
  input logic              r_done,
  input logic              r_err,
  input logic [RATE_W-1:0] r_rate,
  input logic [NR_W-1:0]   r_nr,
  input logic [NO_W-1:0]   r_no,
  input logic [NF_W-1:0]   r_nf,
  input logic [BW_W-1:0]   r_bw
);
  logic [RATE_W-1:0] cap_rate;
  logic              cap_exact;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_rate  <= '0;
      cap_exact <= 1'b0;
    end else if (q_valid && q_ready) begin
      cap_rate  <= q_rate;
      cap_exact <= q_exact;
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_done |=> !r_done);

  // R8
  done_after_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_done) |-> $past(busy));

  // R9
  busy_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !q_ready);

  // R9
  accept_starts_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_ready) |=> busy);

  // R6
  exact_hit_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_done && !r_err && cap_exact) |-> (r_rate == cap_rate));

  // R4
  round_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_done && !r_err) |-> (r_rate != '0));

  // R11
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_done && r_err) |-> (r_rate == '0 && r_nr == '0 && r_no == '0 &&
                           r_nf == '0 && r_bw == '0));
endmodule

bind pll_rate_lookup pll_rate_lookup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_ready(q_ready),
  .q_exact(q_exact), .q_rate(q_rate), .busy(busy), .r_done(r_done),
  .r_err(r_err), .r_rate(r_rate), .r_nr(r_nr), .r_no(r_no), .r_nf(r_nf),
  .r_bw(r_bw)
);

// File: tb/pll_rate_lookup_bench.sv
module pll_rate_lookup_bench;
  localparam int DEPTH = 16;
  localparam int IDX_W = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [IDX_W-1:0]  wr_idx = '0;
  logic [31:0]       wr_rate = '0;
  logic [5:0]        wr_nr = '0;
  logic [3:0]        wr_no = '0;
  logic [12:0]       wr_nf = '0;
  logic [11:0]       wr_bw = '0;
  logic              q_valid = 1'b0;
  logic              q_exact = 1'b0;
  logic [31:0]       q_rate = '0;
  logic              q_ready, busy, r_done, r_err;
  logic [31:0]       r_rate;
  logic [5:0]        r_nr;
  logic [3:0]        r_no;
  logic [12:0]       r_nf;
  logic [11:0]       r_bw;

  int checks = 0;
  int errors = 0;
  int lat_g  = 0;

  logic [31:0] m_rate [DEPTH];
  logic [5:0]  m_nr   [DEPTH];
  logic [3:0]  m_no   [DEPTH];
  logic [12:0] m_nf   [DEPTH];
  logic [11:0] m_bw   [DEPTH];

  always #5 clk = ~clk;

  pll_rate_lookup #(.DEPTH(DEPTH)) u_pll_rate_lookup (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_rate(wr_rate), .wr_nr(wr_nr), .wr_no(wr_no), .wr_nf(wr_nf),
    .wr_bw(wr_bw), .q_valid(q_valid), .q_ready(q_ready), .q_exact(q_exact),
    .q_rate(q_rate), .busy(busy), .r_done(r_done), .r_err(r_err),
    .r_rate(r_rate), .r_nr(r_nr), .r_no(r_no), .r_nf(r_nf), .r_bw(r_bw)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void ref_q(input bit ex, input logic [31:0] req,
                                output bit err, output int sel, output int n);
    err = 1'b1; sel = 0; n = 0;
    for (int i = 0; i < DEPTH; i++) begin
      n = i + 1;
      if (m_rate[i] == 32'd0) begin
        if (!ex && i > 0) begin err = 1'b0; sel = i - 1; end
        return;
      end
      if (!ex) begin
        if (m_rate[i] <= req || i == DEPTH - 1) begin err = 1'b0; sel = i; return; end
      end else begin
        if (m_rate[i] == req) begin err = 1'b0; sel = i; return; end
        if (m_rate[i] < req || i == DEPTH - 1) return;
      end
    end
  endfunction

  task automatic write_ent(input int idx, input logic [31:0] rate, input logic [5:0] nr,
                           input logic [3:0] no, input logic [12:0] nf, input logic [11:0] bw);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_rate = rate;
    wr_nr = nr; wr_no = no; wr_nf = nf; wr_bw = bw;
    @(negedge clk);
    wr_en = 1'b0;
    m_rate[idx] = rate; m_nr[idx] = nr; m_no[idx] = no; m_nf[idx] = nf; m_bw[idx] = bw;
  endtask

  task automatic load_table(input int len);
    int step;
    step = 100_000_000;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < len)
        write_ent(i, 32'((len - i) * step + 1 + ($urandom % (step - 1))),
                  6'($urandom), 4'($urandom), 13'($urandom), 12'($urandom));
      else
        write_ent(i, 32'd0, 6'd0, 4'd0, 13'd0, 12'd0);
    end
  endtask

  task automatic start_query(input bit ex, input logic [31:0] req, input string tag);
    @(negedge clk);
    chk(q_ready == 1'b1, tag, "q_ready idle", 64'(q_ready), 64'd1);
    q_valid = 1'b1; q_exact = ex; q_rate = req;
    @(posedge clk);
    #1 q_valid = 1'b0;
    lat_g = 0;
  endtask

  task automatic finish_query(input bit ex, input logic [31:0] req, input string tag);
    bit e_err; int sel, n;
    ref_q(ex, req, e_err, sel, n);
    forever begin
      @(posedge clk);
      lat_g++;
      @(negedge clk);
      if (r_done) break;
      if (!busy || q_ready) begin
        chk(1'b0, "R9", "busy during scan", 64'(busy), 64'd1);
      end
      if (lat_g > DEPTH + 4) break;
    end
    chk(r_done == 1'b1 && lat_g == n, "R8", {tag, " latency"}, 64'(lat_g), 64'(n));
    chk(r_err == e_err, tag, "err", 64'(r_err), 64'(e_err));
    if (e_err) begin
      chk({r_rate, r_nr, r_no, r_nf, r_bw} == '0, "R11", "zero on error",
          64'(r_rate), 64'd0);
    end else begin
      chk(r_rate == m_rate[sel], tag, "rate", 64'(r_rate), 64'(m_rate[sel]));
      chk({r_nr, r_no, r_nf, r_bw} == {m_nr[sel], m_no[sel], m_nf[sel], m_bw[sel]},
          "R2", "settings", 64'({r_nr, r_no, r_nf, r_bw}),
          64'({m_nr[sel], m_no[sel], m_nf[sel], m_bw[sel]}));
    end
    @(negedge clk);
    chk(r_done == 1'b0, "R8", "done one cycle", 64'(r_done), 64'd0);
  endtask

  task automatic query(input bit ex, input logic [31:0] req, input string tag);
    start_query(ex, req, tag);
    finish_query(ex, req, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < DEPTH; i++) begin
      m_rate[i] = '0; m_nr[i] = '0; m_no[i] = '0; m_nf[i] = '0; m_bw[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy", 64'(busy), 64'd0);
    chk(r_done == 1'b0, "R1", "done", 64'(r_done), 64'd0);
    chk(q_ready == 1'b1, "R1", "q_ready", 64'(q_ready), 64'd1);
    rst_n = 1'b1;

    // R7 empty table after reset
    query(1'b0, 32'd500, "R7");
    query(1'b1, 32'd0, "R7");

    // R3 directed five-entry table with sentinel at 5
    write_ent(0, 32'd1000, 6'd1, 4'd2, 13'd3, 12'd4);
    write_ent(1, 32'd800, 6'd5, 4'd6, 13'd7, 12'd8);
    write_ent(2, 32'd600, 6'd9, 4'd10, 13'd11, 12'd12);
    write_ent(3, 32'd400, 6'd13, 4'd14, 13'd15, 12'd16);
    write_ent(4, 32'd200, 6'd17, 4'd1, 13'd19, 12'd20);
    write_ent(5, 32'd0, 6'd0, 4'd0, 13'd0, 12'd0);
    write_ent(6, 32'd100, 6'd3, 4'd3, 13'd3, 12'd3); // beyond sentinel, R3
    query(1'b0, 32'd5000, "R4");
    query(1'b0, 32'd700, "R4");
    query(1'b0, 32'd400, "R4");
    query(1'b0, 32'd150, "R5");
    query(1'b0, 32'd0, "R5");
    query(1'b1, 32'd600, "R6");
    query(1'b1, 32'd650, "R6");
    query(1'b1, 32'd100, "R3");
    query(1'b1, 32'd50, "R6");

    // R10 write while busy is dropped
    start_query(1'b1, 32'd200, "R10");
    @(negedge clk);
    wr_en = 1'b1; wr_idx = '0; wr_rate = 32'd1200;
    @(posedge clk);
    lat_g++;
    #1 wr_en = 1'b0;
    finish_query(1'b1, 32'd200, "R10");
    query(1'b1, 32'd1000, "R10");
    query(1'b1, 32'd1200, "R10");

    // R10 write in the acceptance cycle is dropped
    @(negedge clk);
    wr_en = 1'b1; wr_idx = '0; wr_rate = 32'd1300;
    q_valid = 1'b1; q_exact = 1'b0; q_rate = 32'd900;
    @(posedge clk);
    #1 q_valid = 1'b0; wr_en = 1'b0;
    lat_g = 0;
    finish_query(1'b0, 32'd900, "R10");
    query(1'b1, 32'd1300, "R10");
    query(1'b1, 32'd1000, "R10");

    // R3 full table without sentinel
    load_table(DEPTH);
    query(1'b0, 32'd1, "R5");
    query(1'b1, 32'd1, "R3");
    query(1'b1, m_rate[DEPTH-1], "R6");

    // random tables and queries
    for (int t = 0; t < 8; t++) begin
      int len;
      len = int'($urandom % (DEPTH + 1));
      load_table(len);
      for (int k = 0; k < 12; k++) begin
        bit ex;
        logic [31:0] rq;
        int pick;
        ex = 1'($urandom);
        pick = int'($urandom % 4);
        if (len > 0 && pick < 2) rq = m_rate[$urandom % len];
        else if (len > 0 && pick == 2) rq = m_rate[$urandom % len] + 32'd1;
        else rq = $urandom % 32'd2_000_000_000;
        query(ex, rq, ex ? "R6" : "R4");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule